// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits between the command decoder of a synchronous DRAM and its column decoder. It holds the operating mode, which is loaded by a mode-register-set command. For every read or write command that opens a burst inside an open 256-column row, it produces one column address per cycle.

The block supports burst lengths of 1, 2, 4 and 8, and full-page bursts. Short bursts wrap inside their aligned group, in either sequential or interleaved order. Full-page bursts run around the whole row until they are stopped or replaced. One mode bit can limit write bursts to a single beat while reads keep the programmed length.

Alongside the addresses, the block raises a read-data-valid strobe. The strobe is delayed by the programmed CAS latency, so the data path knows when read data is on the bus.

Top module: `burst_col_gen`

## Requirements
- R1: During and after reset, `burst_act`, `rd_valid` and `col_addr` are 0, and `col_addr` reads 0 in every cycle in which `burst_act` is low.
- R2: Until a mode load has been accepted, every `start` is refused: `burst_act` stays low.
- R3: A mode load in cycle c sets the mode used from cycle c+1. The fields are decoded as follows. Bits [2:0] give the burst length: 000 is 1, 001 is 2, 010 is 4, 011 is 8, 111 is full page, and any other code is 1. Bit 3 selects the order: 0 is sequential and 1 is interleaved. Bits [6:4] equal to 011 give latency 3; any other value gives latency 2. Bit 9 set makes writes single-beat. A load with bits [8:7] not both 0 is ignored entirely.
- R4: A start accepted in cycle c shows beat k in cycle c+1+k. For a sequential burst of length L, beat k is `(S & ~(L-1)) | ((S+k) & (L-1))`, where S is `start_col`. `burst_act` is high for exactly L cycles and then drops.
- R5: In interleaved order the low log2(L) bits of beat k are `S ^ k`, and the upper bits stay those of S.
- R6: A full-page burst is always sequential. Beat k is `(S+k) mod 256`, and the burst continues past 256 beats until it is stopped or replaced.
- R7: A `stop` sampled in cycle c during a full-page burst makes `burst_act` low from cycle c+1. During any other burst, `stop` has no effect.
- R8: With bit 9 set, a write burst lasts one beat, while a read burst keeps the programmed length.
- R9: For a read beat shown in cycle c+1+k, `rd_valid` is high in cycle c+CL+k, where CL is the latency. Write bursts never raise `rd_valid`.
- R10: A start accepted during a burst replaces it at once. Its first beat follows in the next cycle, so back-to-back reads keep `rd_valid` high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Mode-register-set command strobe |
| mode_word | input | 10 | Mode word sampled with `mode_load` |
| start | input | 1 | Read or write command opening a burst |
| start_is_wr | input | 1 | 1 for a write command, 0 for a read |
| start_col | input | 8 | Start column of the burst |
| stop | input | 1 | Burst stop command |
| col_addr | output | 8 | Column address of the current beat |
| burst_act | output | 1 | A beat is being presented |
| rd_valid | output | 1 | Read data is due on the bus this cycle |

## Verification
The first column of a burst appears one cycle after the start command is sampled, and every following beat arrives one cycle later. The end of a burst and the effect of a stop both show one cycle after the edge that caused them. The read strobe trails the command by exactly the programmed latency of two or three cycles. The bench drives every command on a falling edge and samples on each following falling edge, numbering those samples from 1. The first sample is therefore beat 0, and the expected strobe samples are CL through CL+L-1, computed from the requirement formulas.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  localparam int CL_MIN = 2;
  localparam int CL_MAX = 3;

  localparam int F_BL_LO  = 0;
  localparam int F_BL_HI  = 2;
  localparam int F_ORDER  = 3;
  localparam int F_CL_LO  = 4;
  localparam int F_CL_HI  = 6;
  localparam int F_RSV_LO = 7;
  localparam int F_RSV_HI = 8;
  localparam int F_WR1    = 9;

  localparam logic [2:0] CL3_CODE = 3'b011;
endpackage

// File: rtl/burst_mode_reg.sv
`timescale 1ns/1ps
module burst_mode_reg
  import burst_pkg::*;
#(
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output logic              programmed,
  output logic [2:0]        bl_code,
  output logic              il,
  output logic              cl3,
  output logic              wr_single
);
  logic       prog_q, prog_d;
  logic [2:0] bl_q, bl_d;
  logic       il_q, il_d, cl3_q, cl3_d, ws_q, ws_d;
  logic       accept;

  assign accept = load && (word[F_RSV_HI:F_RSV_LO] == 2'b00);

  always_comb begin
    prog_d = prog_q;
    bl_d   = bl_q;
    il_d   = il_q;
    cl3_d  = cl3_q;
    ws_d   = ws_q;
    if (accept) begin
      prog_d = 1'b1;
      bl_d   = word[F_BL_HI:F_BL_LO];
      il_d   = word[F_ORDER];
      cl3_d  = (word[F_CL_HI:F_CL_LO] == CL3_CODE);
      ws_d   = word[F_WR1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      bl_q   <= 3'b000;
      il_q   <= 1'b0;
      cl3_q  <= 1'b0;
      ws_q   <= 1'b0;
    end else begin
      prog_q <= prog_d;
      bl_q   <= bl_d;
      il_q   <= il_d;
      cl3_q  <= cl3_d;
      ws_q   <= ws_d;
    end
  end

  assign programmed = prog_q;
  assign bl_code    = bl_q;
  assign il         = il_q;
  assign cl3        = cl3_q;
  assign wr_single  = ws_q;
endmodule

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             programmed,
  input  logic [2:0]       bl_code,
  input  logic             il,
  input  logic             wr_single,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col_addr,
  output logic             active,
  output logic             beat_rd,
  output logic             page_burst
);
  logic             act_q, act_d, wr_q, wr_d, il_q, il_d, page_q, page_d;
  logic [COL_W-1:0] k_q, k_d, base_q, base_d, m_q, m_d;
  logic [COL_W-1:0] m_new, offs;
  logic             one_beat, page_new, il_new, last, take;

  assign one_beat = start_wr && wr_single;
  assign page_new = (bl_code == BL_PAGE) && !one_beat;
  assign il_new   = il && !page_new;
  assign take     = start && programmed;

  always_comb begin
    case (bl_code)
      BL_2:    m_new = COL_W'(1);
      BL_4:    m_new = COL_W'(3);
      BL_8:    m_new = COL_W'(7);
      BL_PAGE: m_new = '1;
      default: m_new = '0;
    endcase
    if (one_beat) m_new = '0;
  end

  assign last = (k_q == m_q) && !page_q;

  always_comb begin
    act_d  = act_q;
    k_d    = k_q;
    base_d = base_q;
    m_d    = m_q;
    il_d   = il_q;
    wr_d   = wr_q;
    page_d = page_q;
    if (take) begin
      act_d  = 1'b1;
      k_d    = '0;
      base_d = start_col;
      m_d    = m_new;
      il_d   = il_new;
      wr_d   = start_wr;
      page_d = page_new;
    end else if (act_q) begin
      if ((stop && page_q) || last) act_d = 1'b0;
      k_d = k_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      k_q    <= '0;
      base_q <= '0;
      m_q    <= '0;
      il_q   <= 1'b0;
      wr_q   <= 1'b0;
      page_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      k_q    <= k_d;
      base_q <= base_d;
      m_q    <= m_d;
      il_q   <= il_d;
      wr_q   <= wr_d;
      page_q <= page_d;
    end
  end

  assign offs       = il_q ? (base_q ^ k_q) : (base_q + k_q);
  assign col_addr   = act_q ? ((base_q & ~m_q) | (offs & m_q)) : '0;
  assign active     = act_q;
  assign beat_rd    = act_q && !wr_q;
  assign page_burst = act_q && page_q;
endmodule

// File: rtl/burst_rd_lat.sv
`timescale 1ns/1ps
module burst_rd_lat #(
  parameter int DEPTH = 2,
  parameter int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_rd,
  input  logic [SEL_W-1:0] tap,
  output logic             rd_valid
);
  logic [DEPTH-1:0] pipe_q, pipe_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign pipe_d[g] = beat_rd;
    end else begin : g_tail
      assign pipe_d[g] = pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rd_valid = pipe_q[tap];
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int MODE_W = 10,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic              start_is_wr,
  input  logic [COL_W-1:0]  start_col,
  input  logic              stop,
  output logic [COL_W-1:0]  col_addr,
  output logic              burst_act,
  output logic              rd_valid
);
  localparam int LAT_DEPTH = CL_MAX - CL_MIN + 1;
  localparam int SEL_W     = (LAT_DEPTH > 1) ? $clog2(LAT_DEPTH) : 1;

  logic             programmed, il, cl3, wr_single, beat_rd, page_burst;
  logic [2:0]       bl_code;
  logic [SEL_W-1:0] tap;

  burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .word(mode_word),
    .programmed(programmed), .bl_code(bl_code), .il(il), .cl3(cl3),
    .wr_single(wr_single)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .programmed(programmed), .bl_code(bl_code),
    .il(il), .wr_single(wr_single), .start(start), .start_wr(start_is_wr),
    .start_col(start_col), .stop(stop), .col_addr(col_addr),
    .active(burst_act), .beat_rd(beat_rd), .page_burst(page_burst)
  );

  assign tap = cl3 ? SEL_W'(CL_MAX - CL_MIN) : '0;

  burst_rd_lat #(.DEPTH(LAT_DEPTH), .SEL_W(SEL_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .beat_rd(beat_rd), .tap(tap),
    .rd_valid(rd_valid)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
`timescale 1ns/1ps
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             start_is_wr,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col_addr,
  input logic             burst_act,
  input logic             programmed,
  input logic             wr_single,
  input logic             page_burst
);
  AST_REFUSE_UNPROG: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !programmed) |=> !burst_act); // R2

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && programmed) |=> (burst_act && col_addr == $past(start_col))); // R4

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(burst_act) && page_burst && !$past(start))
      |-> (col_addr == COL_W'($past(col_addr) + COL_W'(1)))); // R6

  AST_PAGE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (page_burst && stop && !start) |=> !burst_act); // R7

  AST_WRITE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start && programmed && start_is_wr && wr_single) && !start)
      |=> !burst_act); // R8
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_is_wr(start_is_wr),
  .start_col(start_col), .stop(stop), .col_addr(col_addr),
  .burst_act(burst_act), .programmed(programmed), .wr_single(wr_single),
  .page_burst(page_burst)
);

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;
  logic       clk, rst_n, mode_load, start, start_is_wr, stop;
  logic [9:0] mode_word;
  logic [7:0] start_col, col_addr;
  logic       burst_act, rd_valid;
  int         total = 0;
  int         fails = 0;

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .start_is_wr(start_is_wr), .start_col(start_col),
    .stop(stop), .col_addr(col_addr), .burst_act(burst_act),
    .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #500000;
    fails++;
    total++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic mrs(int bl, bit il, int cl, bit ws, bit rsv);
    @(negedge clk);
    mode_load = 1'b1;
    mode_word = '0;
    mode_word[2:0] = 3'(bl);
    mode_word[3]   = il;
    mode_word[6:4] = (cl == 3) ? 3'b011 : 3'b010;
    mode_word[7]   = rsv;
    mode_word[9]   = ws;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic cmd(bit wr, logic [7:0] col);
    @(negedge clk);
    start = 1'b1;
    start_is_wr = wr;
    start_col = col;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic burst(string tag, bit wr, logic [7:0] col, int len, bit il,
                       int cl);
    logic [7:0] m, e;
    m = 8'(len - 1);
    cmd(wr, col);
    for (int s = 1; s <= len + cl + 1; s++) begin
      if (s <= len) begin
        e = il ? (col ^ 8'(s - 1)) : (col + 8'(s - 1));
        e = (col & ~m) | (e & m);
        chk({tag, " act"}, burst_act, 1);
        chk({tag, " col"}, col_addr, e);
      end else begin
        chk({tag, " idle"}, burst_act, 0);
        chk({tag, " R1 idle col"}, col_addr, 0);
      end
      chk({tag, " R9 rdv"}, rd_valid,
          (!wr && s >= cl && s < cl + len) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset act", burst_act, 0);
    chk("R1 reset col", col_addr, 0);
    chk("R1 reset rdv", rd_valid, 0);
  endtask

  task automatic t_unprog();
    mrs(2, 0, 2, 0, 1);
    cmd(0, 8'd3);
    chk("R2 refused s1", burst_act, 0);
    @(negedge clk);
    chk("R2 refused s2", burst_act, 0);
    chk("R2 refused rdv", rd_valid, 0);
  endtask

  task automatic t_seq();
    mrs(2, 0, 2, 0, 0);
    burst("R4 bl4 seq", 0, 8'd6, 4, 0, 2);
    mrs(3, 0, 2, 0, 0);
    burst("R4 bl8 seq", 0, 8'h0D, 8, 0, 2);
    mrs(1, 0, 2, 0, 0);
    burst("R4 bl2 seq", 0, 8'h41, 2, 0, 2);
    mrs(0, 0, 2, 0, 0);
    burst("R4 bl1", 0, 8'h99, 1, 0, 2);
    mrs(5, 0, 2, 0, 0);
    burst("R3 reserved bl code", 0, 8'h22, 1, 0, 2);
  endtask

  task automatic t_il();
    mrs(3, 1, 2, 0, 0);
    burst("R5 bl8 il", 0, 8'h35, 8, 1, 2);
    mrs(2, 1, 2, 0, 0);
    burst("R5 bl4 il", 0, 8'h02, 4, 1, 2);
  endtask

  task automatic t_rsv_ignored();
    mrs(2, 0, 2, 0, 0);
    mrs(0, 1, 3, 1, 1);
    burst("R3 rsv load ignored", 0, 8'h11, 4, 0, 2);
  endtask

  task automatic t_cl3();
    mrs(1, 0, 3, 0, 0);
    burst("R9 cl3 bl2", 0, 8'h41, 2, 0, 3);
    burst("R9 cl3 write", 1, 8'h41, 2, 0, 3);
  endtask

  task automatic t_page();
    mrs(7, 1, 2, 0, 0);
    cmd(0, 8'hFE);
    for (int s = 1; s <= 261; s++) begin
      chk("R6 page act", burst_act, 1);
      chk("R6 page col", col_addr, 8'(8'hFE + s - 1));
      if (s == 261) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    chk("R7 page stop act", burst_act, 0);
    chk("R7 page stop col", col_addr, 0);
  endtask

  task automatic t_stop_ignored();
    logic [7:0] e;
    mrs(3, 0, 2, 0, 0);
    cmd(0, 8'h20);
    for (int s = 1; s <= 9; s++) begin
      stop = (s == 3);
      e = (s <= 8) ? 8'(8'h20 + s - 1) : 8'h00;
      chk("R7 stop ignored act", burst_act, (s <= 8) ? 1 : 0);
      chk("R7 stop ignored col", col_addr, e);
      @(negedge clk);
    end
    stop = 1'b0;
  endtask

  task automatic t_wr_single();
    mrs(2, 0, 2, 1, 0);
    burst("R8 write one beat", 1, 8'd5, 1, 0, 2);
    burst("R8 read keeps bl4", 0, 8'd5, 4, 0, 2);
  endtask

  task automatic t_back2back();
    int ecol [7] = '{0, 1, 8, 9, 10, 11, 0};
    mrs(2, 0, 2, 0, 0);
    cmd(0, 8'd0);
    for (int s = 1; s <= 7; s++) begin
      chk("R10 b2b col", col_addr, ecol[s-1]);
      chk("R10 b2b act", burst_act, (s <= 6) ? 1 : 0);
      chk("R10 gapless rdv", rd_valid, (s >= 2) ? 1 : 0);
      if (s == 2) begin
        start = 1'b1;
        start_is_wr = 1'b0;
        start_col = 8'd8;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk("R10 b2b end rdv", rd_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    mode_load = 1'b0;
    mode_word = '0;
    start = 1'b0;
    start_is_wr = 1'b0;
    start_col = '0;
    stop = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unprog();
    t_seq();
    t_il();
    t_rsv_ignored();
    t_cl3();
    t_page();
    t_stop_ignored();
    t_wr_single();
    t_back2back();
    summary();
  end
endmodule